// File: doc/BRIEF.md
# Nibble ALU with Decimal Adjust

This block is the arithmetic and logic unit of a nibble-wide microcontroller datapath. Each cycle it takes a destination operand and a source operand, both 4 bits wide, together with an operation code. It returns a 4-bit result on a combinational path and also tells the surrounding datapath whether that result should be written back. The carry and zero flags live in a small flag register that the block owns. That register also holds the interrupt-enable bit and the decimal-mode bit. The whole register can be loaded at once from outside, which is how the sequencer sets or clears decimal mode and interrupt enable.

The operation set covers:
- addition and subtraction, each with and without the carry as an extra input;
- the three bitwise logic operations and inversion;
- a compare and a bit test, which update flags only;
- rotates in both directions through the carry.

When decimal mode is on, additions and subtractions are adjusted to packed-BCD digits. The adjustment is suppressed in two cases: when the destination is one half of an 8-bit index register, and always for compare. Decimal results are only meaningful when both operands are valid BCD digits (0 to 9).

Top module: `nib_alu`

## Requirements
- R1: After reset the flag register `flags_q` reads 0. Its bit order is {interrupt enable, decimal mode, zero, carry} from bit 3 down to bit 0.
- R2: In binary mode, ADD (code 0) gives the low 4 bits of dst+src, and ADC (code 1) gives the low 4 bits of dst+src+C. In both cases C becomes the carry out of bit 3.
- R3: In binary mode, SUB (code 2) gives the low 4 bits of dst-src, and SBC (code 3) gives the low 4 bits of dst-src-C. In both cases C becomes 1 exactly when a borrow occurs.
- R4: With decimal mode set and `dst_index` low, ADD and ADC adjust their sum. A sum above 9 has 6 added, keeps its low 4 bits and sets C. Otherwise the sum is passed through with C cleared.
- R5: With decimal mode set and `dst_index` low, SUB and SBC adjust on borrow. A difference that borrows has 6 subtracted (low 4 bits kept) and sets C. Otherwise C is cleared.
- R6: When `dst_index` is high, codes 0 to 3 behave exactly as in binary mode, whatever the decimal-mode bit holds.
- R7: CP (code 7) sets C and Z as a binary SUB would, never adjusted for decimal mode. It holds `result_we` low.
- R8: FAN (code 8) sets Z when dst AND src is zero. It leaves C unchanged and holds `result_we` low.
- R9: AND (4), OR (5), XOR (6) and NOT (11, which inverts dst) write their result and leave C unchanged.
- R10: RRC (9) returns {C, dst[3:1]} and loads C from dst[0]. RLC (10) returns {dst[2:0], C} and loads C from dst[3].
- R11: After every accepted operation with codes 0 to 11, Z equals 1 exactly when the 4-bit `result` of that cycle was zero.
- R12: The interrupt-enable and decimal-mode bits change only through `flag_wr`. A flag load replaces all four bits and overrides an operation issued in the same cycle.
- R13: Codes 12 to 15, and cycles with `op_valid` low, leave every flag unchanged and hold `result_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation code (0 to 11; 12 to 15 reserved) |
| opnd_dst | input | 4 | Destination operand |
| opnd_src | input | 4 | Source operand |
| dst_index | input | 1 | Destination is one half of an index register |
| flag_wr | input | 1 | Load the flag register from `flag_wdata` |
| flag_wdata | input | 4 | New flags {IE, D, Z, C} |
| result | output | 4 | Combinational operation result |
| result_we | output | 1 | The destination should take `result` |
| flags_q | output | 4 | Flag register {IE, D, Z, C} |

## Verification
A corrupted flag register shows up one cycle after the bad update, and it can show up in two ways. It appears directly on `flags_q`. It also reaches `result` in the next cycle that uses the carry or the decimal-mode bit, such as ADC, SBC, a rotate or a decimal add. A wrong adjustment decision shows in `result` within the same cycle, as a value that is off by 6 or a digit above 9. A wrong write-enable decode is visible at once on `result_we` for compare and bit test.

// File: rtl/nib_alu_pkg.sv
// Package for the nibble ALU: operation codes and flag bit positions.
package nib_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CP  = 4'd7,
        OP_FAN = 4'd8,
        OP_RRC = 4'd9,
        OP_RLC = 4'd10,
        OP_NOT = 4'd11
    } alu_op_e;

    localparam int FLG_C  = 0;
    localparam int FLG_Z  = 1;
    localparam int FLG_D  = 2;
    localparam int FLG_IE = 3;
    localparam int FLG_W  = 4;

    // True for the four add/subtract codes.
    function automatic logic is_addsub(input logic [3:0] op);
        return op <= OP_SBC;
    endfunction

    // True for codes that are defined at all.
    function automatic logic is_defined(input logic [3:0] op);
        return op <= OP_NOT;
    endfunction

endpackage

// File: rtl/nib_addsub.sv
// Adder/subtractor with optional carry-in and decimal adjust.
// Assumes W = 4 when dec_en is used: the adjust works on a single BCD digit.
module nib_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         use_cin,
    input  logic         sub,
    input  logic         dec_en,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam logic [W:0]   DEC_MAX = (W+1)'(9);
    localparam logic [W-1:0] DEC_ADJ = W'(6);

    logic [W:0] raw;
    logic [W:0] ct;

    // Form the raw wide sum or difference.
    always_comb begin
        ct  = {{W{1'b0}}, (use_cin & cin)};
        raw = sub ? ({1'b0, a} - {1'b0, b} - ct)
                  : ({1'b0, a} + {1'b0, b} + ct);
    end

    // Apply the decimal adjust and derive carry/borrow.
    always_comb begin
        sum  = raw[W-1:0];
        cout = raw[W];
        if (dec_en) begin
            if (!sub) begin
                if (raw > DEC_MAX) begin
                    sum  = raw[W-1:0] + DEC_ADJ;
                    cout = 1'b1;
                end else begin
                    cout = 1'b0;
                end
            end else if (raw[W]) begin
                sum  = raw[W-1:0] - DEC_ADJ;
                cout = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nib_logic.sv
// Bitwise, bit-test, rotate and invert unit.
// Assumes op holds one of the logic-side codes; other codes give a, with the carry kept.
module nib_logic #(
    parameter int W = 4
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    import nib_alu_pkg::*;

    // Select the logic result and the carry produced by rotates.
    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_AND, OP_FAN: res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_NOT:         res = ~a;
            OP_RRC: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            OP_RLC: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nib_flags.sv
// Flag register {IE, D, Z, C}. A full load has priority over an update from an operation.
module nib_flags #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] load_val,
    input  logic          upd,
    input  logic          z_in,
    input  logic          c_in,
    output logic [FW-1:0] q
);
    import nib_alu_pkg::*;

    // Hold, load or update the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (upd) begin
            q[FLG_Z] <= z_in;
            q[FLG_C] <= c_in;
        end
    end
endmodule

// File: rtl/nib_alu.sv
// Nibble ALU top: decodes the operation, routes operands to the add/sub and
// logic units, and updates the flag register. The result path is combinational.
// Assumes the sequencer presents operands and the code in the cycle op_valid is high.
module nib_alu #(
    parameter int W  = 4,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [OW-1:0] op_code,
    input  logic [W-1:0]  opnd_dst,
    input  logic [W-1:0]  opnd_src,
    input  logic          dst_index,
    input  logic          flag_wr,
    input  logic [3:0]    flag_wdata,
    output logic [W-1:0]  result,
    output logic          result_we,
    output logic [3:0]    flags_q
);
    import nib_alu_pkg::*;

    logic         arith_sel;
    logic         sub_sel;
    logic         cin_sel;
    logic         dec_on;
    logic [W-1:0] as_sum;
    logic         as_cout;
    logic [W-1:0] lg_res;
    logic         lg_cout;
    logic         c_next;
    logic         upd;

    // Decode which unit serves the operation and its options.
    always_comb begin
        arith_sel = is_addsub(op_code) || (op_code == OP_CP);
        sub_sel   = (op_code == OP_SUB) || (op_code == OP_SBC) || (op_code == OP_CP);
        cin_sel   = (op_code == OP_ADC) || (op_code == OP_SBC);
        dec_on    = flags_q[FLG_D] && !dst_index && is_addsub(op_code);
    end

    nib_addsub #(.W(W)) u_addsub (
        .a       (opnd_dst),
        .b       (opnd_src),
        .cin     (flags_q[FLG_C]),
        .use_cin (cin_sel),
        .sub     (sub_sel),
        .dec_en  (dec_on),
        .sum     (as_sum),
        .cout    (as_cout)
    );

    nib_logic #(.W(W)) u_logic (
        .op   (op_code),
        .a    (opnd_dst),
        .b    (opnd_src),
        .cin  (flags_q[FLG_C]),
        .res  (lg_res),
        .cout (lg_cout)
    );

    // Pick the result, next carry and write-back enable.
    always_comb begin
        result    = arith_sel ? as_sum : lg_res;
        c_next    = arith_sel ? as_cout : lg_cout;
        upd       = op_valid && is_defined(op_code);
        result_we = upd && (op_code != OP_CP) && (op_code != OP_FAN);
    end

    nib_flags #(.FW(FLG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (flag_wr),
        .load_val (flag_wdata),
        .upd      (upd),
        .z_in     (result == '0),
        .c_in     (c_next),
        .q        (flags_q)
    );
endmodule

// File: rtl/nib_alu_chk.sv
// Checker for nib_alu: relates operations to the flag register one cycle later.
module nib_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_code,
    input logic [3:0] opnd_dst,
    input logic [3:0] opnd_src,
    input logic       dst_index,
    input logic       flag_wr,
    input logic [3:0] result,
    input logic       result_we,
    input logic [3:0] flags_q
);
    // A valid operation is accepted by the flag register.
    logic op_ok;
    assign op_ok = op_valid && !flag_wr && (op_code <= 4'd11);

    assert_bcd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[2] && !dst_index && op_code <= 4'd1 && opnd_dst <= 4'd9 && opnd_src <= 4'd9)
        |-> result <= 4'd9);

    assert_cp_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd7 || op_code == 4'd8) |-> !result_we);

    assert_fan_keeps_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ok && op_code == 4'd8) |=> flags_q[0] == $past(flags_q[0]));

    assert_logic_keeps_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ok && (op_code inside {4'd4, 4'd5, 4'd6, 4'd11})) |=> flags_q[0] == $past(flags_q[0]));

    assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_ok |=> flags_q[1] == ($past(result) == 4'd0));

    assert_ctrl_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> flags_q[3:2] == $past(flags_q[3:2]));

    assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && (!op_valid || op_code > 4'd11)) |=> $stable(flags_q));
endmodule

bind nib_alu nib_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd_dst  (opnd_dst),
    .opnd_src  (opnd_src),
    .dst_index (dst_index),
    .flag_wr   (flag_wr),
    .result    (result),
    .result_we (result_we),
    .flags_q   (flags_q)
);

// File: tb/nib_alu_test.sv
module nib_alu_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [3:0] op_code;
    logic [3:0] opnd_dst;
    logic [3:0] opnd_src;
    logic       dst_index;
    logic       flag_wr;
    logic [3:0] flag_wdata;
    logic [3:0] result;
    logic       result_we;
    logic [3:0] flags_q;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    logic [3:0]  exp_fl;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    nib_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_dst(opnd_dst), .opnd_src(opnd_src), .dst_index(dst_index),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .result(result),
        .result_we(result_we), .flags_q(flags_q)
    );

    // Reference: returns {we, result[3:0], carry_out, flags_update}.
    function automatic logic [6:0] model(input logic [3:0] op, input logic [3:0] a,
                                         input logic [3:0] b, input logic [3:0] fl,
                                         input logic idx);
        logic [4:0] s;
        logic [3:0] r;
        logic       c;
        logic       dec;
        logic       ci;
        c   = fl[0];
        r   = a;
        ci  = (op == 4'd1 || op == 4'd3) ? fl[0] : 1'b0;
        dec = fl[2] && !idx;
        case (op)
            4'd0, 4'd1: begin
                s = 5'(a) + 5'(b) + 5'(ci);
                if (dec) begin
                    c = (s > 5'd9);
                    r = c ? 4'(s + 5'd6) : s[3:0];
                end else begin
                    c = s[4]; r = s[3:0];
                end
            end
            4'd2, 4'd3, 4'd7: begin
                s = 5'(a) - 5'(b) - 5'(ci);
                c = ({1'b0, a} < 5'(b) + 5'(ci));
                r = (dec && op != 4'd7 && c) ? 4'(s[3:0] - 4'd6) : s[3:0];
            end
            4'd4, 4'd8: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd9:  begin r = {fl[0], a[3:1]}; c = a[0]; end
            4'd10: begin r = {a[2:0], fl[0]}; c = a[3]; end
            4'd11: r = ~a;
            default: ;
        endcase
        return {(op <= 4'd11 && op != 4'd7 && op != 4'd8), r, c, (op <= 4'd11)};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op, input logic [3:0] fl, input logic idx);
        if (op > 4'd11) return "R13";
        if (op <= 4'd3 && fl[2] && idx) return "R6";
        if (op <= 4'd1) return fl[2] ? "R4" : "R2";
        if (op <= 4'd3) return fl[2] ? "R5" : "R3";
        if (op == 4'd7) return "R7";
        if (op == 4'd8) return "R8";
        if (op == 4'd9 || op == 4'd10) return "R10";
        return "R9";
    endfunction

    // Issue one operation: check the combinational outputs, then the flags a cycle later.
    task automatic run_op(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                          input logic idx);
        logic [6:0] m;
        string      rq;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_dst = a; opnd_src = b; dst_index = idx;
        #1;
        m  = model(op, a, b, exp_fl, idx);
        rq = req_of(op, exp_fl, idx);
        if (m[6] && op != 4'd7 && op != 4'd8) check(rq, result, m[5:2]);
        check(rq, {3'b0, result_we}, {3'b0, m[6]});
        if (m[0]) begin
            exp_fl[0] = m[1];
            exp_fl[1] = (m[5:2] == 4'd0);
        end
        @(negedge clk);
        op_valid = 1'b0;
        check((m[0] ? "R11" : "R13"), flags_q, exp_fl);
    endtask

    task automatic load_flags(input logic [3:0] v, input logic with_op);
        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = v;
        op_valid = with_op; op_code = 4'd0; opnd_dst = 4'd9; opnd_src = 4'd9;
        @(negedge clk);
        flag_wr = 1'b0; op_valid = 1'b0;
        exp_fl = v;
        check("R12", flags_q, exp_fl);
    endtask

    initial begin
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; opnd_dst = '0; opnd_src = '0;
        dst_index = 1'b0; flag_wr = 1'b0; flag_wdata = '0;
        exp_fl = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", flags_q, 4'h0);

        // Binary arithmetic corners (R2, R3).
        run_op(4'd0, 4'hF, 4'h1, 1'b0);   // R2: wraps to 0, C=1, Z=1
        run_op(4'd1, 4'h7, 4'h8, 1'b0);   // R2: 7+8+1 = 0 carry
        run_op(4'd2, 4'h3, 4'h5, 1'b0);   // R3: borrow
        run_op(4'd3, 4'h5, 4'h3, 1'b0);   // R3: 5-3-1
        // Decimal mode (R4, R5, R6, R7).
        load_flags(4'b0100, 1'b0);
        run_op(4'd0, 4'h5, 4'h7, 1'b0);   // R4: 12 -> 2, C=1
        run_op(4'd1, 4'h9, 4'h9, 1'b0);   // R4: 9+9+1 -> 9, C=1
        run_op(4'd0, 4'h5, 4'h5, 1'b0);   // R4: 10 -> 0, Z=1
        run_op(4'd2, 4'h0, 4'h9, 1'b0);   // R5: -> 1, C=1
        run_op(4'd0, 4'h5, 4'h7, 1'b1);   // R6: binary C
        run_op(4'd7, 4'h3, 4'h5, 1'b0);   // R7: binary compare
        // Logic and rotates (R8, R9, R10).
        load_flags(4'b1001, 1'b1);        // R12: load wins over issued op
        run_op(4'd8, 4'hA, 4'h5, 1'b0);   // R8
        run_op(4'd9, 4'h1, 4'h0, 1'b0);   // R10
        run_op(4'd10, 4'h8, 4'h0, 1'b0);  // R10
        run_op(4'd11, 4'hF, 4'h0, 1'b0);  // R9
        run_op(4'd13, 4'h0, 4'h0, 1'b0);  // R13
        // Random mix.
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 16) == 0)
                load_flags(4'($urandom), 1'($urandom));
            else
                run_op(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule